// File: doc/BRIEF.md
# Multiplexed Bus Address Demultiplexer and ROM Bank Decoder

This block connects a microcontroller that shares one 8-bit bus between address and data to two external program ROM banks. While the address strobe is high, the low address byte passes through from the shared bus. A holding register keeps that byte once the strobe falls, when the same lines begin to carry data. The block joins the held byte with the high address bits to form a 16-bit address. Each ROM bank gets only the address bits its configured size needs.

The enable clock marks the data phase. A ROM bank is selected only in the upper half of the address space, and address bit 14 chooses the bank. Every select and every bus-drive control is gated by the enable clock, so no ROM drives the shared lines while the address is being captured. On a read the block drives the selected bank's data toward the processor. On a write it raises a write strobe and keeps the last byte it took from the bus.

Top module: `mbus_demux`

## Requirements
- R1: While `as_i` is high, `addr_o[7:0]` equals `ad_i` in the same cycle.
- R2: While `as_i` is low, `addr_o[7:0]` holds the value `ad_i` had at the last rising clock edge at which `as_i` was high. Changes on `ad_i` do not affect it. After reset it is 0.
- R3: `addr_o[15:8]` always equals `addr_hi_i`.
- R4: `rom_sel_o[0]` (upper bank) is high exactly when `e_i`, address bit 15 and address bit 14 are all high.
- R5: `rom_sel_o[1]` (lower bank) is high exactly when `e_i` and address bit 15 are high and address bit 14 is low.
- R6: While `e_i` is low, `rom_sel_o` is 0, whatever the address.
- R7: `rom0_a_o` equals `addr_o[ROM0_AW-1:0]` and `rom1_a_o` equals `addr_o[ROM1_AW-1:0]`. ROM0_AW and ROM1_AW are each 11, 12 or 13, for a 2K, 4K or 8K device.
- R8: `bus_oe_o` is high exactly when `e_i`, `rw_i` (1 = read) and address bit 15 are high. While it is high, `bus_o` carries the selected bank's data. Otherwise `bus_o` is 0.
- R9: `wr_stb_o` is high exactly when `e_i` is high and `rw_i` is low. `wr_data_o` takes `ad_i` at each rising edge where `wr_stb_o` is high, and holds it otherwise (0 after reset).
- R10: A write never raises `bus_oe_o`, not even inside the ROM region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| as_i | input | 1 | Address strobe |
| e_i | input | 1 | Enable clock, data phase |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_hi_i | input | 8 | Address bits 15..8 |
| ad_i | input | 8 | Shared address/data bus, input side |
| rom0_q_i | input | 8 | Data from the upper bank |
| rom1_q_i | input | 8 | Data from the lower bank |
| addr_o | output | 16 | Demultiplexed full address |
| rom_sel_o | output | 2 | Bank selects, bit 0 upper, bit 1 lower |
| rom0_a_o | output | ROM0_AW | Upper bank address |
| rom1_a_o | output | ROM1_AW | Lower bank address |
| bus_o | output | 8 | Read data toward the processor |
| bus_oe_o | output | 1 | Drive enable for bus_o |
| wr_stb_o | output | 1 | Write data phase |
| wr_data_o | output | 8 | Last byte taken from the bus on a write |

## Verification
A holding register that captured the wrong byte, or was disturbed in the data phase, shows on `addr_o[7:0]` and on both bank addresses in the first cycle after the strobe falls. It remains visible until the next strobe. A bad decode or a missing enable gate shows in the same cycle on `rom_sel_o` or `bus_oe_o`: a bank or the drive is active during the address phase, during a write, or outside the ROM region. A stale write register shows on `wr_data_o` one cycle after the enable phase.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int unsigned BUS_W   = 8;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned N_BANKS = 2;

  typedef enum logic [1:0] {
    BANK_NONE = 2'b00,
    BANK_HI   = 2'b01,
    BANK_LO   = 2'b10
  } bank_e;
endpackage

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch
  import mbus_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             as_i,
  input  logic [BUS_W-1:0] ad_i,
  output logic [BUS_W-1:0] lo_o
);
  logic [BUS_W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   held_q <= '0;
    else if (as_i) held_q <= ad_i;
  end

  // transparent during the strobe, held afterwards
  assign lo_o = as_i ? ad_i : held_q;

  a_r2_hold_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_i && $past(!as_i)) |-> $stable(lo_o));
endmodule

// File: rtl/mbus_rom_decode.sv
module mbus_rom_decode
  import mbus_pkg::*;
#(
  parameter int unsigned ROM0_AW = 13,
  parameter int unsigned ROM1_AW = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               e_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [N_BANKS-1:0] sel_o,
  output logic [ROM0_AW-1:0] rom0_a_o,
  output logic [ROM1_AW-1:0] rom1_a_o
);
  localparam int unsigned A_REGION = ADDR_W - 1;
  localparam int unsigned A_BANK   = ADDR_W - 2;

  bank_e bank;

  always_comb begin
    bank = BANK_NONE;
    if (e_i && addr_i[A_REGION])
      bank = addr_i[A_BANK] ? BANK_HI : BANK_LO;
  end

  assign sel_o    = bank;
  assign rom0_a_o = addr_i[ROM0_AW-1:0];
  assign rom1_a_o = addr_i[ROM1_AW-1:0];

  a_r6_no_sel_addr_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !e_i |-> (sel_o == '0));
  a_r4_one_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  a_r5_region_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != '0) |-> addr_i[A_REGION]);
endmodule

// File: rtl/mbus_data_steer.sv
module mbus_data_steer
  import mbus_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         e_i,
  input  logic                         rw_i,
  input  logic [N_BANKS-1:0]           sel_i,
  input  logic [N_BANKS-1:0][BUS_W-1:0] rom_q_i,
  input  logic [BUS_W-1:0]             ad_i,
  output logic [BUS_W-1:0]             bus_o,
  output logic                         bus_oe_o,
  output logic                         wr_stb_o,
  output logic [BUS_W-1:0]             wr_data_o
);
  logic rd_phase;
  logic [N_BANKS-1:0][BUS_W-1:0] masked;
  logic [BUS_W-1:0] wd_q;

  assign rd_phase = e_i & rw_i;

  for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
    assign masked[g] = (rd_phase && sel_i[g]) ? rom_q_i[g] : '0;
  end

  always_comb begin
    bus_o = '0;
    for (int i = 0; i < N_BANKS; i++) bus_o |= masked[i];
  end

  assign bus_oe_o = rd_phase & (|sel_i);
  assign wr_stb_o = e_i & ~rw_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wd_q <= '0;
    else if (wr_stb_o) wd_q <= ad_i;
  end
  assign wr_data_o = wd_q;

  a_r10_no_drive_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rw_i |-> !bus_oe_o);
  a_r9_wdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!wr_stb_o) |-> $stable(wr_data_o));
endmodule

// File: rtl/mbus_demux.sv
module mbus_demux
  import mbus_pkg::*;
#(
  parameter int unsigned ROM0_AW = 13,
  parameter int unsigned ROM1_AW = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               as_i,
  input  logic               e_i,
  input  logic               rw_i,
  input  logic [7:0]         addr_hi_i,
  input  logic [7:0]         ad_i,
  input  logic [7:0]         rom0_q_i,
  input  logic [7:0]         rom1_q_i,
  output logic [15:0]        addr_o,
  output logic [1:0]         rom_sel_o,
  output logic [ROM0_AW-1:0] rom0_a_o,
  output logic [ROM1_AW-1:0] rom1_a_o,
  output logic [7:0]         bus_o,
  output logic               bus_oe_o,
  output logic               wr_stb_o,
  output logic [7:0]         wr_data_o
);
  logic [BUS_W-1:0] lo;
  logic [N_BANKS-1:0][BUS_W-1:0] rom_q;

  mbus_addr_latch u_latch (
    .clk_i, .rst_ni, .as_i, .ad_i, .lo_o(lo)
  );

  assign addr_o = {addr_hi_i, lo};
  assign rom_q  = {rom1_q_i, rom0_q_i};

  mbus_rom_decode #(.ROM0_AW(ROM0_AW), .ROM1_AW(ROM1_AW)) u_dec (
    .clk_i, .rst_ni, .e_i, .addr_i(addr_o),
    .sel_o(rom_sel_o), .rom0_a_o, .rom1_a_o
  );

  mbus_data_steer u_steer (
    .clk_i, .rst_ni, .e_i, .rw_i, .sel_i(rom_sel_o), .rom_q_i(rom_q), .ad_i,
    .bus_o, .bus_oe_o, .wr_stb_o, .wr_data_o
  );

  a_r8_drive_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (e_i && rw_i && addr_o[15]));
  a_r1_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_i |-> (addr_o[7:0] == ad_i));
endmodule

// File: tb/tb_mbus_demux.sv
module tb_mbus_demux;
  localparam int AW0 = 13;
  localparam int AW1 = 12;
  localparam logic [7:0] Q0 = 8'h3C;
  localparam logic [7:0] Q1 = 8'hC3;

  logic clk = 0, rst_ni = 0;
  logic as_i = 0, e_i = 0, rw_i = 1;
  logic [7:0] addr_hi_i = 0, ad_i = 0;
  logic [15:0] addr_o;
  logic [1:0] rom_sel_o;
  logic [AW0-1:0] rom0_a_o;
  logic [AW1-1:0] rom1_a_o;
  logic [7:0] bus_o, wr_data_o;
  logic bus_oe_o, wr_stb_o;

  always #10 clk = ~clk;

  mbus_demux #(.ROM0_AW(AW0), .ROM1_AW(AW1)) dut (
    .clk_i(clk), .rst_ni, .as_i, .e_i, .rw_i, .addr_hi_i, .ad_i,
    .rom0_q_i(Q0), .rom1_q_i(Q1), .addr_o, .rom_sel_o, .rom0_a_o, .rom1_a_o,
    .bus_o, .bus_oe_o, .wr_stb_o, .wr_data_o
  );

  typedef struct {
    string tag;
    logic [15:0] addr;
    logic [1:0] sel;
    logic [AW0-1:0] a0;
    logic [AW1-1:0] a1;
    logic [7:0] bus;
    logic oe, wstb;
    logic [7:0] wd;
  } exp_t;

  exp_t q[$];
  int n_tests = 0, n_fail = 0;
  logic [7:0] m_lo = 0, m_wd = 0;
  bit done = 0;

  task automatic step(input logic as, e, rw, input logic [7:0] hi, ad, input string tag);
    exp_t x;
    logic [7:0] lo;
    logic hit;
    @(posedge clk); #2;
    as_i = as; e_i = e; rw_i = rw; addr_hi_i = hi; ad_i = ad;
    lo = as ? ad : m_lo;
    hit = e & hi[7];
    x.tag = tag;
    x.addr = {hi, lo};
    x.sel = {hit & ~hi[6], hit & hi[6]};
    x.a0 = x.addr[AW0-1:0];
    x.a1 = x.addr[AW1-1:0];
    x.oe = e & rw & hi[7];
    x.bus = x.oe ? (hi[6] ? Q0 : Q1) : 8'h00;
    x.wstb = e & ~rw;
    x.wd = m_wd;
    q.push_back(x);
    if (as) m_lo = ad;
    if (e && !rw) m_wd = ad;
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      n_tests++;
      if (addr_o !== x.addr || rom_sel_o !== x.sel || rom0_a_o !== x.a0 ||
          rom1_a_o !== x.a1 || bus_o !== x.bus || bus_oe_o !== x.oe ||
          wr_stb_o !== x.wstb || wr_data_o !== x.wd) begin
        n_fail++;
        $display("FAIL %s: act addr=%h sel=%b a0=%h a1=%h bus=%h oe=%b wstb=%b wd=%h exp addr=%h sel=%b a0=%h a1=%h bus=%h oe=%b wstb=%b wd=%h",
          x.tag, addr_o, rom_sel_o, rom0_a_o, rom1_a_o, bus_o, bus_oe_o, wr_stb_o, wr_data_o,
          x.addr, x.sel, x.a0, x.a1, x.bus, x.oe, x.wstb, x.wd);
      end
    end
  end

  // read cycle: strobe phase, address hold, enable phase, end
  task automatic rd_cycle(input logic [7:0] hi, lo, junk, input string tag);
    step(1, 0, 1, hi, lo,   {tag, " R1 strobe, R6 no select"});
    step(0, 0, 1, hi, junk, {tag, " R2 hold, R6 e low"});
    step(0, 1, 1, hi, junk, {tag, " R4/R5 bank, R8 read drive, R7"});
    step(0, 0, 1, hi, ~junk, {tag, " R2 hold after e falls"});
  endtask

  task automatic wr_cycle(input logic [7:0] hi, lo, d, input string tag);
    step(1, 0, 0, hi, lo, {tag, " R1 strobe"});
    step(0, 1, 0, hi, d,  {tag, " R9 write strobe, R10 no drive"});
    step(0, 0, 0, hi, 8'h5A, {tag, " R9 data held"});
  endtask

  initial begin
    // reset state
    #5;
    n_tests++;
    if (addr_o !== 16'h0000 || rom_sel_o !== 2'b00 || bus_oe_o !== 1'b0 ||
        wr_data_o !== 8'h00 || wr_stb_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 reset: act addr=%h sel=%b oe=%b wd=%h exp 0000 00 0 00",
        addr_o, rom_sel_o, bus_oe_o, wr_data_o);
    end
    @(posedge clk); #2; rst_ni = 1;

    rd_cycle(8'hC1, 8'h23, 8'hEE, "upper bank read");
    rd_cycle(8'h9F, 8'hFF, 8'h00, "lower bank read, R7 bits truncated");
    rd_cycle(8'hFF, 8'h00, 8'h77, "upper bank top");
    rd_cycle(8'h80, 8'h01, 8'h81, "lower bank base");
    rd_cycle(8'h7F, 8'hAA, 8'h55, "R3 outside region read");
    wr_cycle(8'h20, 8'h10, 8'h96, "write outside region");
    wr_cycle(8'hC0, 8'h04, 8'h69, "R10 write inside region");
    wr_cycle(8'h00, 8'h00, 8'h00, "write zero data");
    // strobe held over several cycles with changing bus: R1 transparency
    step(1, 0, 1, 8'hA0, 8'h11, "R1 transparent a");
    step(1, 0, 1, 8'hA0, 8'h22, "R1 transparent b");
    step(0, 0, 1, 8'hA0, 8'h99, "R2 last strobed byte kept");
    step(0, 1, 1, 8'hA0, 8'h98, "R5 lower bank after long strobe");
    step(0, 0, 1, 8'h00, 8'h00, "idle");
    wait (q.size() == 0);
    @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: act timeout exp completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule